// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register Bank

This block is the software-visible control plane of a network controller. A host reaches it over a word-wide bus. Each access carries a 6-bit register index and 16 bits of data. Reads are combinational from the index. A write takes effect on the clock edge at which `wr_en_i` is high.

The block holds four kinds of state:
- a command register, whose bits start actions;
- an interrupt mask and an interrupt status register, which produce a single level interrupt;
- configuration, ring-pointer and tally registers, each with its own write rule.

A write to the command register raises one-cycle strobes on `pulse_o`. These go to the engines that do the actual work, which sit outside this block: transmit, receive, the timer and the descriptor fetch. The halt, transmit, read-resource and load-table bits stay set in the command register until the owning engine returns an acknowledge on `done_i`. The engines report events through `evt_set_i`, and each event sets the matching status bit.

Top module: `nic_regbank`

## Requirements
- R1: After reset the bank reads as follows:
  - command (index 0x00) = 0x0094;
  - end-of-buffer count (0x0C) = 0x02F8;
  - mask (0x04), status (0x05) and address-enable (0x0D) = 0;
  - revision (0x3F) = 0x0004.
- R2: `irq_o` is high exactly when the mask and status registers have a common set bit. It reflects a write to either register from the cycle after that write.
- R3: A write to status (0x05) clears only the written-1 bits that are currently set. Each `evt_set_i` bit sets its status bit on the next edge, and a set wins over a clear in the same cycle.
- R4: Mask (0x04) stores only bits 14:0, and bit 15 always reads as 0.
- R5: A command write (0x00) is masked with 0x03BF and ORed into the command register. In the following cycle `pulse_o` carries the accepted bits, in the same positions: 0 halt, 1 transmit, 2 rx off, 3 rx on, 4 timer stop, 5 timer start, 8 read resource, 9 load table. Bit 7 never pulses.
- R6: While command bit 7 (soft reset) is set, a command write without bit 7 clears bit 7 only and raises no pulse.
- R7: A command write with bit 7:
  - clears bits 0, 1, 8 and 9;
  - sets bits 7 and 2;
  - raises no pulse on bits 0, 1, 8 or 9.
- R8: Writing rx-on clears rx-off, and writing rx-off clears rx-on. Writing timer-start clears timer-stop, and writing timer-stop clears timer-start.
- R9: A `done_i` bit clears its command bit only for bits 0, 1, 8 and 9. Other `done_i` bits are ignored.
- R10: The data config register (0x01, mask 0xBFFF) and the second config register (0x14, mask 0xF017) accept writes only while command bit 7 is set.
- R11: Write masks:
  - tx control (0x03) keeps bits 15:12;
  - rx control (0x02) keeps bits 15:5;
  - the ring start, end, read and write pointers (0x08 to 0x0B) force bit 0 to 0.
- R12: The three tally registers (0x10 CRC errors, 0x11 alignment errors, 0x12 missed packets) store the inverse of the written value. Revision ignores writes. Unmapped indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 6 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| evt_set_i | input | 16 | Event inputs that set status bits |
| done_i | input | 10 | Action acknowledges from the engines, aligned to command bits |
| pulse_o | output | 10 | One-cycle action strobes, aligned to command bits |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus presents at most one register write per cycle. They also assume that `evt_set_i` and `done_i` are sampled as plain levels, so an engine that holds `done_i` high keeps clearing its bit. The status-clear property is only claimed in cycles where no event arrives.

The stimulus drives bus and event inputs at the falling edge and holds `wr_en_i` high for one cycle per write. It pulses `done_i` and `evt_set_i` for a single cycle, except for the one deliberate case where an event and a clear of the same bit coincide. A behavioural model in the bench compares `irq_o`, `pulse_o` and the addressed read data after every rising edge.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int CW = 10;

  localparam logic [AW-1:0] A_CMD   = 6'h00;
  localparam logic [AW-1:0] A_IMASK = 6'h04;
  localparam logic [AW-1:0] A_ISTAT = 6'h05;
  localparam logic [AW-1:0] A_REV   = 6'h3F;

  localparam int C_HALT   = 0;
  localparam int C_TX     = 1;
  localparam int C_RXOFF  = 2;
  localparam int C_RXON   = 3;
  localparam int C_TSTOP  = 4;
  localparam int C_TSTART = 5;
  localparam int C_SRST   = 7;
  localparam int C_RDRES  = 8;
  localparam int C_LDTAB  = 9;

  localparam logic [CW-1:0] CMD_WMASK = 10'h3BF;
  localparam logic [CW-1:0] CMD_DONE  = 10'h303;  // engine-owned bits
  localparam logic [CW-1:0] CMD_RST   = 10'h094;
  localparam logic [DW-1:0] IMASK_WM  = 16'h7FFF;
  localparam logic [DW-1:0] REV_VAL   = 16'h0004;

  // generic config slots
  localparam int NCFG = 13;
  localparam logic [AW-1:0] CFG_ADDR [NCFG] = '{
    6'h01, 6'h14, 6'h02, 6'h03, 6'h08, 6'h09, 6'h0A, 6'h0B,
    6'h0C, 6'h0D, 6'h10, 6'h11, 6'h12};
  localparam logic [DW-1:0] CFG_WMASK [NCFG] = '{
    16'hBFFF, 16'hF017, 16'hFFE0, 16'hF000, 16'hFFFE, 16'hFFFE, 16'hFFFE,
    16'hFFFE, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
  localparam logic [DW-1:0] CFG_RSTV [NCFG] = '{
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
    16'h0000, 16'h02F8, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [NCFG-1:0] CFG_LOCK = 13'b0000000000011;  // slot i -> bit i
  localparam logic [NCFG-1:0] CFG_INV  = 13'b1110000000000;
endpackage

// File: rtl/nic_cfg_reg.sv
module nic_cfg_reg
  import nic_regbank_pkg::*;
#(
  parameter logic [DW-1:0] WMASK   = '1,
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter bit            INVERT  = 1'b0,
  parameter bit            LOCKED  = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          unlock_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic          wr_ok;
  logic [DW-1:0] wval;

  assign wr_ok = we_i && (!LOCKED || unlock_i);

  generate
    if (INVERT) begin : g_inv
      assign wval = ~wdata_i & WMASK;
    end else begin : g_plain
      assign wval = wdata_i & WMASK;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (wr_ok) q_o <= wval;
  end

  generate
    if (LOCKED) begin : g_lock_chk
      // R10: writes outside soft reset leave the register untouched
      a_r10_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !unlock_i) |=> $stable(q_o));
    end
  endgenerate
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_regbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_we_i,
  input  logic          stat_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] stat_o,
  output logic          irq_o
);
  logic [DW-1:0] clr;

  assign clr = stat_we_i ? (wdata_i & stat_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      stat_o <= '0;
    end else begin
      if (mask_we_i) mask_o <= wdata_i & IMASK_WM;
      stat_o <= (stat_o & ~clr) | set_i;
    end
  end

  assign irq_o = |(mask_o & stat_o);

  a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && set_i == '0) |=> ((stat_o & $past(wdata_i)) == '0));
  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));
  a_r4_mask_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> !mask_o[DW-1]);
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_regbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [CW-1:0] done_i,
  output logic [CW-1:0] cmd_o,
  output logic [CW-1:0] pulse_o
);
  logic [CW-1:0] acc, nxt, pls;
  logic          sticky_exit;

  assign acc         = wdata_i & CMD_WMASK;
  assign sticky_exit = cmd_o[C_SRST] && !wdata_i[C_SRST];

  always_comb begin
    nxt = cmd_o;
    pls = '0;
    if (we_i) begin
      if (sticky_exit) begin
        nxt[C_SRST] = 1'b0;
      end else begin
        nxt = nxt | acc;
        if (acc[C_RXOFF])  nxt[C_RXON]   = 1'b0;
        if (acc[C_RXON])   nxt[C_RXOFF]  = 1'b0;
        if (acc[C_TSTOP])  nxt[C_TSTART] = 1'b0;
        if (acc[C_TSTART]) nxt[C_TSTOP]  = 1'b0;
        pls = acc;
        pls[C_SRST] = 1'b0;
        if (acc[C_SRST]) begin
          nxt = nxt & ~CMD_DONE;
          nxt[C_SRST]  = 1'b1;
          nxt[C_RXOFF] = 1'b1;
          pls = pls & ~CMD_DONE;
        end
      end
    end
    nxt = nxt & ~(done_i & CMD_DONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= CMD_RST;
      pulse_o <= '0;
    end else begin
      cmd_o   <= nxt;
      pulse_o <= pls;
    end
  end

  a_r5_pulse_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o != '0) |-> $past(we_i));
  a_r6_sticky_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cmd_o[C_SRST] && !wdata_i[C_SRST]) |=> (pulse_o == '0 && !cmd_o[C_SRST]));
  a_r7_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[C_SRST]) |=>
      (cmd_o[C_SRST] && cmd_o[C_RXOFF] && (pulse_o & CMD_DONE) == '0));
  a_r8_rx_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sticky_exit && wdata_i[C_RXON] && !wdata_i[C_RXOFF] && !wdata_i[C_SRST])
      |=> (cmd_o[C_RXON] && !cmd_o[C_RXOFF]));
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] evt_set_i,
  input  logic [CW-1:0] done_i,
  output logic [CW-1:0] pulse_o,
  output logic          irq_o
);
  logic [CW-1:0] cmd_q;
  logic [DW-1:0] mask_q, stat_q;
  logic [DW-1:0] cfg_q [NCFG];

  nic_cmd_ctrl u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && addr_i == A_CMD),
    .wdata_i (wdata_i[CW-1:0]),
    .done_i  (done_i),
    .cmd_o   (cmd_q),
    .pulse_o (pulse_o)
  );

  nic_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (wr_en_i && addr_i == A_IMASK),
    .stat_we_i (wr_en_i && addr_i == A_ISTAT),
    .wdata_i   (wdata_i),
    .set_i     (evt_set_i),
    .mask_o    (mask_q),
    .stat_o    (stat_q),
    .irq_o     (irq_o)
  );

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    nic_cfg_reg #(
      .WMASK   (CFG_WMASK[g]),
      .RST_VAL (CFG_RSTV[g]),
      .INVERT  (CFG_INV[g]),
      .LOCKED  (CFG_LOCK[g])
    ) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_en_i && addr_i == CFG_ADDR[g]),
      .unlock_i (cmd_q[C_SRST]),
      .wdata_i  (wdata_i),
      .q_o      (cfg_q[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CMD:   rdata_o = {{(DW-CW){1'b0}}, cmd_q};
      A_IMASK: rdata_o = mask_q;
      A_ISTAT: rdata_o = stat_q;
      A_REV:   rdata_o = REV_VAL;
      default: begin
        for (int i = 0; i < NCFG; i++)
          if (addr_i == CFG_ADDR[i]) rdata_o = cfg_q[i];
      end
    endcase
  end

  a_r2_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_IMASK && wdata_i == '0 && evt_set_i == '0) |=> !irq_o);
endmodule

// File: tb/nic_regbank_tb.sv
module nic_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] evt = '0;
  logic [9:0]  done = '0;
  logic [9:0]  pulse;
  logic        irq;

  always #4 clk = ~clk;  // 8 ns period

  nic_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_set_i(evt), .done_i(done),
    .pulse_o(pulse), .irq_o(irq)
  );

  int total = 0;
  int bad = 0;
  logic [15:0] m [0:63];
  logic [9:0]  m_pulse;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 64; i++) m[i] = 16'h0;
      m[6'h00] = 16'h0094;
      m[6'h0C] = 16'h02F8;
      m[6'h3F] = 16'h0004;
      m_pulse  = '0;
    end else begin
      logic [15:0] c, a, clrv;
      m_pulse = '0;
      clrv = 16'h0;
      if (wr_en) begin
        case (addr)
          6'h00: begin
            c = m[0];
            if (c[7] && !wdata[7]) c[7] = 1'b0;
            else begin
              a = wdata & 16'h03BF;
              c = c | a;
              if (a[2]) c[3] = 1'b0;
              if (a[3]) c[2] = 1'b0;
              if (a[4]) c[5] = 1'b0;
              if (a[5]) c[4] = 1'b0;
              m_pulse = a[9:0] & ~10'h080;
              if (a[7]) begin
                c = (c & ~16'h0303) | 16'h0084;
                m_pulse = m_pulse & ~10'h303;
              end
            end
            m[0] = c;
          end
          6'h01: if (m[0][7]) m[1] = wdata & 16'hBFFF;
          6'h14: if (m[0][7]) m[6'h14] = wdata & 16'hF017;
          6'h02: m[2] = wdata & 16'hFFE0;
          6'h03: m[3] = wdata & 16'hF000;
          6'h04: m[4] = wdata & 16'h7FFF;
          6'h05: clrv = wdata;
          6'h08, 6'h09, 6'h0A, 6'h0B: m[addr] = wdata & 16'hFFFE;
          6'h0C, 6'h0D: m[addr] = wdata;
          6'h10, 6'h11, 6'h12: m[addr] = ~wdata;
          default: ;
        endcase
      end
      m[5] = (m[5] & ~clrv) | evt;
      m[0] = m[0] & ~({6'h0, done} & 16'h0303);
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_ni) begin
      check("R2 irq per cycle", {15'h0, irq}, {15'h0, |(m[4] & m[5])});
      check("R5 pulse per cycle", {6'h0, pulse}, {6'h0, m_pulse});
      check("R11 rdata per cycle", rdata, m[addr]);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_p(input logic [15:0] d, input logic [9:0] exp_p, input string tag);
    wr(6'h00, d);
    check(tag, {6'h0, pulse}, {6'h0, exp_p});
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a;
    #1 check(tag, rdata, exp);
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(6'h00, 16'h0094, "R1 cmd");
    rd(6'h0C, 16'h02F8, "R1 eob");
    rd(6'h04, 16'h0000, "R1 mask");
    rd(6'h05, 16'h0000, "R1 status");
    rd(6'h0D, 16'h0000, "R1 addr-enable");
    rd(6'h3F, 16'h0004, "R1 revision");
    check("R2 irq reset", {15'h0, irq}, 16'h0);
    // R10 writable in soft reset
    wr(6'h01, 16'hFFFF); rd(6'h01, 16'hBFFF, "R10 dcfg");
    wr(6'h14, 16'hFFFF); rd(6'h14, 16'hF017, "R10 dcfg2");
    // R6 sticky reset exit
    wr_p(16'h0000, 10'h000, "R6 no pulse");
    rd(6'h00, 16'h0014, "R6 cmd");
    wr(6'h01, 16'h1234); rd(6'h01, 16'hBFFF, "R10 locked");
    wr(6'h14, 16'h0000); rd(6'h14, 16'hF017, "R10 locked2");
    // R11 masks
    wr(6'h03, 16'hFFFF); rd(6'h03, 16'hF000, "R11 txc");
    wr(6'h02, 16'hFFFF); rd(6'h02, 16'hFFE0, "R11 rxc");
    wr(6'h08, 16'h1235); rd(6'h08, 16'h1234, "R11 ring start");
    wr(6'h0B, 16'hFFFF); rd(6'h0B, 16'hFFFE, "R11 ring wr");
    // R12 tallies, revision, unmapped
    wr(6'h10, 16'h00FF); rd(6'h10, 16'hFF00, "R12 tally crc");
    wr(6'h12, 16'h0000); rd(6'h12, 16'hFFFF, "R12 tally miss");
    wr(6'h3F, 16'h1234); rd(6'h3F, 16'h0004, "R12 revision");
    wr(6'h30, 16'hFFFF); rd(6'h30, 16'h0000, "R12 unmapped");
    // R4 mask top bit
    wr(6'h04, 16'hFFFF); rd(6'h04, 16'h7FFF, "R4 mask");
    check("R2 irq no status", {15'h0, irq}, 16'h0);
    // R3 events and clear
    @(negedge clk); evt = 16'h0480;
    @(negedge clk); evt = 16'h0;
    rd(6'h05, 16'h0480, "R3 set");
    check("R2 irq set", {15'h0, irq}, 16'h1);
    wr(6'h05, 16'h0081); rd(6'h05, 16'h0400, "R3 w1c partial");
    wr(6'h04, 16'h0080);
    check("R2 irq masked", {15'h0, irq}, 16'h0);
    wr(6'h04, 16'h0400);
    check("R2 irq unmasked", {15'h0, irq}, 16'h1);
    @(negedge clk); addr = 6'h05; wdata = 16'h0400; wr_en = 1'b1; evt = 16'h0400;
    @(negedge clk); wr_en = 1'b0; evt = 16'h0;
    rd(6'h05, 16'h0400, "R3 set wins");
    wr(6'h05, 16'h0400); rd(6'h05, 16'h0000, "R3 cleared");
    check("R2 irq cleared", {15'h0, irq}, 16'h0);
    // R5 command strobes
    wr_p(16'h0302, 10'h302, "R5 pulse");
    rd(6'h00, 16'h0316, "R5 cmd or");
    // R9 acknowledges
    @(negedge clk); done = 10'h002;
    @(negedge clk); done = 10'h000;
    rd(6'h00, 16'h0314, "R9 tx ack");
    @(negedge clk); done = 10'h014;
    @(negedge clk); done = 10'h000;
    rd(6'h00, 16'h0314, "R9 ignored ack");
    // R8 exclusive pairs
    wr_p(16'h0008, 10'h008, "R8 rx on pulse");
    rd(6'h00, 16'h0318, "R8 rx on");
    wr_p(16'h0020, 10'h020, "R8 start pulse");
    rd(6'h00, 16'h0328, "R8 start");
    wr_p(16'h0040, 10'h000, "R5 masked bit");
    rd(6'h00, 16'h0328, "R5 masked cmd");
    // R7 soft reset
    wr_p(16'h0080, 10'h000, "R7 pulse");
    rd(6'h00, 16'h00AC, "R7 cmd");
    wr_p(16'h0302, 10'h000, "R6 sticky pulse");
    rd(6'h00, 16'h002C, "R6 sticky cmd");
    wr_p(16'h0091, 10'h010, "R7 mixed pulse");
    rd(6'h00, 16'h009C, "R7 mixed cmd");
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule